// File: doc/BRIEF.md
# Prioritised Sound Interrupt Event Controller

This block gathers numbered event requests from the sound subsystem and turns them into one fast-interrupt line for an embedded processor. Each event arrives as a one-cycle pulse with a binary event number. The block keeps one pending bit per event number. It also holds a status code that software reads to learn which event to service next.

Software acknowledges through a decoded clear-write strobe. Clear writes are counted, and only every fourth one retires an event. A retire removes the lowest-numbered pending event and loads the status code with the lowest number still pending. The interrupt line stays high while any event is pending. Out of reset the block behaves as if event 2, a timer event, had just fired.

The status code does not simply track the lowest pending number. A code of zero is treated as free, so a new arrival always overwrites it, even when event 0 is the one pending. Otherwise a new arrival overwrites the code only when its number is lower than the current code.

Top module: `snd_evt_irq_ctrl`

## Requirements
- R1: After reset, pending_o is 8'b0000_0100 (only event 2 pending), status_o is 2, irq_o is 1, and the clear-write count is zero.
- R2: An event pulse (evt_valid=1 with binary number evt_id) sets bit evt_id of pending_o one cycle later. irq_o is 1 whenever pending_o is non-zero.
- R3: On an event pulse, status_o becomes evt_id if status_o read 0 or evt_id is lower than status_o. Otherwise status_o is unchanged.
- R4: Clear writes (clr_wr=1) are counted modulo four. The first, second and third write of each group of four leave pending_o and status_o unchanged.
- R5: The fourth clear write clears the lowest set bit of pending_o. It then sets status_o to the lowest number still pending, or to 0 if none remains.
- R6: irq_o falls to 0 in the cycle after a retire leaves pending_o empty.
- R7: Clear writes with pending_o empty are still counted. They leave status_o at 0 and irq_o at 0.
- R8: When an event pulse and a fourth clear write fall in the same cycle, the retire is applied first. The event is then merged in, and the R3 rule is judged against the post-retire status code.
- R9: An event pulse for an already pending number leaves pending_o unchanged but still applies the R3 status rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| evt_valid | input | 1 | One-cycle event pulse |
| evt_id | input | 3 | Binary event number carried with evt_valid |
| clr_wr | input | 1 | Decoded clear-write strobe, one per bus write |
| irq_o | output | 1 | Fast-interrupt request, high while any event is pending |
| status_o | output | 3 | Event code readable by software |
| pending_o | output | 8 | Pending set, bit i for event i |

## Verification
An event pulse and the fourth clear write can land in the same cycle. In that cycle the retire and the merge both act on the pending set and the status code. Directed sequences place an event pulse exactly on the fourth clear write. Some of these events are lower than the post-retire code and some are higher, and one lands when the retire empties the set. Random stimulus adds more of these collisions. Each result is compared with a bench model that applies the retire first and the merge second.

// File: rtl/snd_irq_pkg.sv
`timescale 1ns/1ps
package snd_irq_pkg;

  localparam int MAX_EVT = 32;

  // index of the lowest set bit among the first n bits; 0 when none is set
  function automatic logic [4:0] lowest_of(input logic [MAX_EVT-1:0] v, input int n);
    logic [4:0] r;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i[4:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/snd_rst_sync.sv
`timescale 1ns/1ps
module snd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/snd_ack_count.sv
`timescale 1ns/1ps
module snd_ack_count #(
  parameter int ACK_WRITES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wr,
  output logic ack_o
);

  localparam int CNT_W = (ACK_WRITES > 1) ? $clog2(ACK_WRITES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_WRITES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             term;

  // terminal flag: this strobe completes a group
  assign term   = clr_wr && (cnt_q == LAST);
  assign cnt_en = clr_wr;

  always_comb begin
    cnt_d = cnt_q;
    if (term)        cnt_d = '0;
    else if (clr_wr) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ack_o = term;

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ack_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (cnt_q == '0));
  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> $stable(cnt_q));

endmodule

// File: rtl/snd_pend_mask.sv
`timescale 1ns/1ps
module snd_pend_mask
  import snd_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ID_W    = $clog2(NUM_EVT),
  parameter int RST_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [ID_W-1:0]    evt_id,
  input  logic               ack,
  output logic [NUM_EVT-1:0] pend_q,
  output logic [NUM_EVT-1:0] kept_o,
  output logic               retire_o,
  output logic               irq_q
);

  localparam logic [NUM_EVT-1:0] RST_MASK = NUM_EVT'(1) << RST_EVT;

  logic [NUM_EVT-1:0] evt_hot;
  logic [NUM_EVT-1:0] low_hot;
  logic [NUM_EVT-1:0] pend_d;
  logic [ID_W-1:0]    low_idx;
  logic               any_pend;
  logic               pend_en;
  logic               irq_d;

  assign any_pend = |pend_q;
  assign low_idx  = lowest_of(MAX_EVT'(pend_q), NUM_EVT)[ID_W-1:0];
  assign retire_o = ack && any_pend;

  always_comb begin
    evt_hot = '0;
    evt_hot[evt_id] = 1'b1;
    low_hot = '0;
    low_hot[low_idx] = 1'b1;
  end

  // retire first, merge the new event afterwards
  always_comb begin
    kept_o = retire_o ? (pend_q & ~low_hot) : pend_q;
    pend_d = evt_valid ? (kept_o | evt_hot) : kept_o;
    irq_d  = |pend_d;
  end

  assign pend_en = evt_valid || retire_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_MASK;
      irq_q  <= 1'b1;
    end else if (pend_en) begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  // R2
  irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (pend_q != '0));
  // R2
  evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> pend_q[$past(evt_id)]);
  // R5
  retire_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_o && !evt_valid) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !ack) |=> $stable(pend_q));

endmodule

// File: rtl/snd_status_reg.sv
`timescale 1ns/1ps
module snd_status_reg
  import snd_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ID_W    = $clog2(NUM_EVT),
  parameter int RST_EVT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [ID_W-1:0]    evt_id,
  input  logic               retire,
  input  logic [NUM_EVT-1:0] kept,
  output logic [ID_W-1:0]    status_q
);

  logic [ID_W-1:0] next_low;
  logic [ID_W-1:0] base;
  logic [ID_W-1:0] status_d;
  logic            take_evt;
  logic            stat_en;

  assign next_low = lowest_of(MAX_EVT'(kept), NUM_EVT)[ID_W-1:0];

  always_comb begin
    // post-retire code: next lowest pending, or zero when the set empties
    base = status_q;
    if (retire) base = (kept != '0) ? next_low : '0;
    // a code of zero counts as free and is always overwritten
    take_evt = evt_valid && ((base == '0) || (evt_id < base));
    status_d = take_evt ? evt_id : base;
  end

  assign stat_en = evt_valid || retire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= ID_W'(RST_EVT);
    else if (stat_en) status_q <= status_d;
  end

  // R4
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !retire) |=> $stable(status_q));
  // R5
  stat_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !evt_valid && (kept == '0)) |=> (status_q == '0));
  // R3
  stat_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !retire && (status_q != '0) && (evt_id > status_q)) |=> $stable(status_q));

endmodule

// File: rtl/snd_evt_irq_ctrl.sv
`timescale 1ns/1ps
module snd_evt_irq_ctrl #(
  parameter int NUM_EVT    = 8,
  parameter int ID_W       = $clog2(NUM_EVT),
  parameter int RST_EVT    = 2,
  parameter int ACK_WRITES = 4,
  parameter int SYNC_STG   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [ID_W-1:0]    evt_id,
  input  logic               clr_wr,
  output logic               irq_o,
  output logic [ID_W-1:0]    status_o,
  output logic [NUM_EVT-1:0] pending_o
);

  logic               rst_i_n;
  logic               ack;
  logic               retire;
  logic [NUM_EVT-1:0] kept;

  snd_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  snd_ack_count #(.ACK_WRITES(ACK_WRITES)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .clr_wr (clr_wr),
    .ack_o  (ack)
  );

  snd_pend_mask #(.NUM_EVT(NUM_EVT), .ID_W(ID_W), .RST_EVT(RST_EVT)) u_pend (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .evt_valid (evt_valid),
    .evt_id    (evt_id),
    .ack       (ack),
    .pend_q    (pending_o),
    .kept_o    (kept),
    .retire_o  (retire),
    .irq_q     (irq_o)
  );

  snd_status_reg #(.NUM_EVT(NUM_EVT), .ID_W(ID_W), .RST_EVT(RST_EVT)) u_stat (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .evt_valid (evt_valid),
    .evt_id    (evt_id),
    .retire    (retire),
    .kept      (kept),
    .status_q  (status_o)
  );

  // R7
  empty_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pending_o == '0) |-> (status_o == '0));
  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (retire && !evt_valid && (kept == '0)) |=> !irq_o);

endmodule

// File: tb/snd_evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module snd_evt_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid;
  logic [2:0] evt_id;
  logic       clr_wr;
  logic       irq_o;
  logic [2:0] status_o;
  logic [7:0] pending_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_pend;
  logic [2:0] m_stat;
  int         m_cnt;

  always #4 clk = ~clk;

  snd_evt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id),
    .clr_wr(clr_wr), .irq_o(irq_o), .status_o(status_o), .pending_o(pending_o)
  );

  function automatic logic [2:0] low_of(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic void model_step(input bit v, input logic [2:0] id, input bit c);
    if (c) begin
      if (m_cnt == 3) begin
        m_cnt = 0;
        if (m_pend != 0) begin
          m_pend[low_of(m_pend)] = 1'b0;
          m_stat = (m_pend != 0) ? low_of(m_pend) : 3'd0;
        end
      end else m_cnt++;
    end
    if (v) begin
      m_pend[id] = 1'b1;
      if (m_stat == 0 || id < m_stat) m_stat = id;
    end
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (pending_o !== m_pend || status_o !== m_stat || irq_o !== (m_pend != 0)) begin
      n_bad++;
      $display("FAIL %s: pend=%b stat=%0d irq=%b expected pend=%b stat=%0d irq=%b",
               tag, pending_o, status_o, irq_o, m_pend, m_stat, (m_pend != 0));
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cyc(input bit v, input logic [2:0] id, input bit c, input string tag);
    evt_valid = v; evt_id = id; clr_wr = c;
    @(posedge clk);
    model_step(v, id, c);
    @(negedge clk);
    check(tag);
  endtask

  task automatic clears(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_id = '0; clr_wr = 1'b0;
    m_pend = 8'b0000_0100; m_stat = 3'd2; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 3'd0, 1'b0, "R1 after release");

    // R4: three writes do nothing, the fourth retires event 2 (R5, R6)
    clears(3, "R4 partial group");
    cyc(1'b0, 3'd0, 1'b1, "R5 R6 fourth write empties set");

    // R3: zero code is overwritten, lower wins, higher does not
    cyc(1'b1, 3'd5, 1'b0, "R3 load on zero");
    cyc(1'b1, 3'd3, 1'b0, "R3 lower wins");
    cyc(1'b1, 3'd6, 1'b0, "R3 higher ignored");
    cyc(1'b1, 3'd3, 1'b0, "R9 repeat event");
    clears(4, "R5 retire lowest");

    // R8: event on the fourth write, lower than post-retire code
    clears(3, "R4 partial group");
    cyc(1'b1, 3'd1, 1'b1, "R8 event lower than post-retire");
    // R8: event higher than post-retire code
    clears(3, "R4 partial group");
    cyc(1'b1, 3'd7, 1'b1, "R8 event higher than post-retire");
    // R8: drain to one, then the retire empties the set as an event lands
    clears(4, "R5 drain");
    clears(3, "R4 partial group");
    cyc(1'b1, 3'd4, 1'b1, "R8 event on emptying retire");
    clears(4, "R6 empty again");

    // R7: writes with empty set are counted; count restarts after four
    clears(4, "R7 empty writes");
    cyc(1'b1, 3'd0, 1'b0, "R3 event zero");
    cyc(1'b1, 3'd4, 1'b0, "R3 zero code overwritten by 4");
    clears(3, "R7 count restarted");
    cyc(1'b0, 3'd0, 1'b1, "R5 retire event zero");

    void'($urandom(32'd5417));
    for (int k = 0; k < 3000; k++) begin
      bit v, c;
      logic [2:0] id;
      v  = ($urandom % 100) < 30;
      c  = ($urandom % 100) < 50;
      id = 3'($urandom % 8);
      cyc(v, id, c, "R2 R3 R5 R8 random");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule